// File: doc/BRIEF.md
# Block-Linear Bitfield Merger

This block takes three per-axis coordinate words (x, y and z), each already packed by an upstream coordinate clamp stage, plus a flag that marks the access as three-dimensional. It merges them into one 32-bit bitfield and a single out-of-bounds predicate. A later address stage adds that bitfield to a base address. The memory access itself happens further downstream.

Two layouts are supported, and the layout is selected per access by flag bits carried inside the x and y words.

- **Block-linear layout.** The element position inside a 64x8-byte tile is scattered into the low byte by a fixed swizzle. The block then counts how many tile-index bits each axis contributes. Finally it concatenates the z, y and x tile indices into a tile-space coordinate whose field widths vary from access to access.
- **Two-dimensional pitch-linear layout.** The block emits only a shifted byte offset and the element-size shift.

One register stage holds the result, with a valid flag that follows the input valid.

Top module: `tile_field_merge`

## Requirements
- R1: Output bit 11 is 1 (pitch-linear layout) when bit 30 of x or bit 30 of y is set, and 0 (block-linear layout) otherwise.
- R2: In block-linear layout, out[3:0]=x[19:16], out[4]=y[16], out[5]=y[17], out[6]=x[20], out[7]=y[18] and out[8]=x[21].
- R3: In block-linear layout, out[15:12] is the sum of three tile counts: x[27] (one bit), y[29:27], and z[29:27]. The z count is taken as 0 when the 3D flag is clear.
- R4: In block-linear layout, the tile-space coordinate is built from three parts, each masked to its own count. The x part is x[23:22] masked to the x count. The y part is y[23:19] masked to min(y count, TILE_CAP) bits. The z part is z[23:16] masked to min(z count, TILE_CAP) bits. The coordinate is ((z_part << y count) | y_part) << x count, ORed with x_part, and it is placed in out[26:16].
- R5: The tile-space coordinate is masked to 10 bits when the x count is 0 and to 11 bits when it is 1.
- R6: In pitch-linear layout, out[7:0] = (z[7:0] << x[29:27]) truncated to 8 bits and out[14:12] = x[29:27]. Bits 26:15 and bit 8 are zero in this layout.
- R7: The out-of-bounds output is x[31] OR y[31] OR (z[31] AND the 3D flag).
- R8: Output bits 31:27, 10 and 9 are always zero.
- R9: An input accepted with in_valid high appears on out_field/out_oob one clock later with out_valid high. A cycle with in_valid low drives out_valid low the next clock and leaves out_field and out_oob unchanged.
- R10: Synchronous active-high reset clears out_valid, out_field and out_oob.
- R11: In block-linear layout with the 3D flag clear, the z word has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input words are valid this cycle |
| in_x | input | 32 | Packed x-axis word |
| in_y | input | 32 | Packed y-axis word |
| in_z | input | 32 | Packed z-axis word |
| in_3d | input | 1 | Access is three-dimensional |
| out_valid | output | 1 | Registered result is valid |
| out_field | output | 32 | Merged bitfield |
| out_oob | output | 1 | Merged out-of-bounds predicate |

## Verification
The bench builds the block with its default TILE_CAP of 5. That value leaves the 3-bit y and z counts room to exceed the cap: a count of 7 truncates the y and z parts to five bits while still shifting them by the full count. The same vectors push the packed coordinate past bit 10, so both the 10-bit and the 11-bit output masks are exercised. Pitch-linear vectors carry deliberate junk in the tile fields, and block-linear vectors with the 3D flag clear carry junk in z, which shows that unselected inputs cannot leak into the result.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  localparam int WORD_W     = 32;
  localparam int CNT_W      = 3;   // per-axis tile count width
  localparam int SUM_W      = 4;   // summed tile count width
  localparam int COORD_W    = 11;  // tile-space coordinate field width
  localparam int WIDE_W     = 16;  // intermediate width, no bit lost
  localparam int LOW_W      = 9;   // swizzled interior bits
  localparam int PL_BYTE_W  = 8;

  // output field positions
  localparam int POS_LAYOUT = 11;
  localparam int POS_COUNT  = 12;
  localparam int POS_COORD  = 16;

  typedef logic [CNT_W-1:0]   cnt_t;
  typedef logic [SUM_W-1:0]   sum_t;
  typedef logic [COORD_W-1:0] coord_t;
endpackage

// File: rtl/tfm_interior_swizzle.sv
module tfm_interior_swizzle
  import tfm_pkg::*;
(
  input  logic [5:0]       x_el,   // x[21:16]
  input  logic [2:0]       y_el,   // y[18:16]
  output logic [LOW_W-1:0] low
);
  always_comb begin
    low      = '0;
    low[3:0] = x_el[3:0];
    low[4]   = y_el[0];
    low[5]   = y_el[1];
    low[6]   = x_el[4];
    low[7]   = y_el[2];
    low[8]   = x_el[5];
  end
endmodule

// File: rtl/tfm_tile_pack.sv
module tfm_tile_pack
  import tfm_pkg::*;
#(
  parameter int TILE_CAP = 5
) (
  input  logic       x_cnt,   // x[27]
  input  logic       x_idx,   // x[22]
  input  cnt_t       y_cnt,   // y[29:27]
  input  logic [4:0] y_idx,   // y[23:19]
  input  cnt_t       z_cnt,   // z[29:27]
  input  logic [7:0] z_idx,   // z[23:16]
  input  logic       is_3d,
  output sum_t       count,
  output coord_t     coord
);
  localparam cnt_t CAP = cnt_t'(TILE_CAP);

  cnt_t              z_eff;
  cnt_t              y_cap;
  cnt_t              z_cap;
  logic [WIDE_W-1:0] a_part;
  logic [WIDE_W-1:0] b_part;
  logic [WIDE_W-1:0] c_part;
  logic [WIDE_W-1:0] wide;

  always_comb begin
    z_eff  = is_3d ? z_cnt : '0;
    y_cap  = (y_cnt > CAP) ? CAP : y_cnt;
    z_cap  = (z_eff > CAP) ? CAP : z_eff;
    count  = sum_t'(x_cnt) + sum_t'(y_cnt) + sum_t'(z_eff);
    a_part = WIDE_W'(x_idx & x_cnt);
    b_part = WIDE_W'(y_idx) & ((WIDE_W'(1) << y_cap) - WIDE_W'(1));
    c_part = WIDE_W'(z_idx) & ((WIDE_W'(1) << z_cap) - WIDE_W'(1));
    wide   = (((c_part << y_cnt) | b_part) << x_cnt) | a_part;
    coord  = x_cnt ? wide[COORD_W-1:0] : {1'b0, wide[COORD_W-2:0]};
  end
endmodule

// File: rtl/tfm_pitch_offset.sv
module tfm_pitch_offset
  import tfm_pkg::*;
(
  input  cnt_t                 shift,   // x[29:27]
  input  logic [PL_BYTE_W-1:0] z_lo,    // z[7:0]
  output logic [PL_BYTE_W-1:0] low
);
  logic [WIDE_W-1:0] shifted;

  always_comb begin
    shifted = WIDE_W'(z_lo) << shift;
    low     = shifted[PL_BYTE_W-1:0];
  end
endmodule

// File: rtl/tile_field_merge.sv
module tile_field_merge
  import tfm_pkg::*;
#(
  parameter int TILE_CAP = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_x,
  input  logic [WORD_W-1:0] in_y,
  input  logic [WORD_W-1:0] in_z,
  input  logic              in_3d,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_field,
  output logic              out_oob
);
  logic [LOW_W-1:0]     bl_low;
  sum_t                 bl_count;
  coord_t               bl_coord;
  logic [PL_BYTE_W-1:0] pl_low;
  logic                 pitch;
  logic                 oob_d;
  logic [WORD_W-1:0]    field_d;
  logic                 unused_bits;

  assign unused_bits = ^{in_x[26:23], in_x[15:0], in_y[26:24], in_y[15:0],
                         in_z[30], in_z[26:24], in_z[15:8]};

  tfm_interior_swizzle u_swz (
    .x_el (in_x[21:16]),
    .y_el (in_y[18:16]),
    .low  (bl_low)
  );

  tfm_tile_pack #(.TILE_CAP(TILE_CAP)) u_pack (
    .x_cnt (in_x[27]),
    .x_idx (in_x[22]),
    .y_cnt (in_y[29:27]),
    .y_idx (in_y[23:19]),
    .z_cnt (in_z[29:27]),
    .z_idx (in_z[23:16]),
    .is_3d (in_3d),
    .count (bl_count),
    .coord (bl_coord)
  );

  tfm_pitch_offset u_pl (
    .shift (in_x[29:27]),
    .z_lo  (in_z[7:0]),
    .low   (pl_low)
  );

  always_comb begin
    pitch   = in_x[30] | in_y[30];
    oob_d   = in_x[31] | in_y[31] | (in_z[31] & in_3d);
    field_d = '0;
    field_d[POS_LAYOUT] = pitch;
    if (pitch) begin
      field_d[PL_BYTE_W-1:0]           = pl_low;
      field_d[POS_COUNT +: CNT_W]      = in_x[29:27];
    end else begin
      field_d[LOW_W-1:0]               = bl_low;
      field_d[POS_COUNT +: SUM_W]      = bl_count;
      field_d[POS_COORD +: COORD_W]    = bl_coord;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_field <= '0;
      out_oob   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_field <= field_d;
        out_oob   <= oob_d;
      end
    end
  end
endmodule

// File: rtl/tfm_checker.sv
module tfm_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        x_oob,
  input logic        y_oob,
  input logic        z_oob,
  input logic        x_pl,
  input logic        y_pl,
  input logic        in_3d,
  input logic        out_valid,
  input logic [31:0] out_field,
  input logic        out_oob
);
  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_field) && $stable(out_oob))); // R9

  AST_OOB_MERGE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_oob == $past(x_oob | y_oob | (z_oob & in_3d)))); // R7

  AST_LAYOUT_FLAG: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_field[11] == $past(x_pl | y_pl))); // R1

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_field[31:27] == 5'd0) && (out_field[10:9] == 2'd0)); // R8

  AST_PITCH_CLEAN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_field[11]) |-> (out_field[26:15] == 12'd0 && !out_field[8])); // R6

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!out_valid && out_field == 32'd0 && !out_oob)); // R10
endmodule

bind tile_field_merge tfm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .x_oob     (in_x[31]),
  .y_oob     (in_y[31]),
  .z_oob     (in_z[31]),
  .x_pl      (in_x[30]),
  .y_pl      (in_y[30]),
  .in_3d     (in_3d),
  .out_valid (out_valid),
  .out_field (out_field),
  .out_oob   (out_oob)
);

// File: tb/tile_field_merge_test.sv
module tile_field_merge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_x = '0, in_y = '0, in_z = '0;
  logic        in_3d = 1'b0;
  logic        out_valid;
  logic [31:0] out_field;
  logic        out_oob;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  tile_field_merge #(.TILE_CAP(5)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_x(in_x), .in_y(in_y), .in_z(in_z), .in_3d(in_3d),
    .out_valid(out_valid), .out_field(out_field), .out_oob(out_oob)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] x;
    logic [31:0] y;
    logic [31:0] z;
    logic        d3;
    logic [31:0] exp_field;
    logic        exp_oob;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd8,  32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b0}, // R8 all zero
    '{4'd2,  32'h003F_0000, 32'h0007_0000, 32'h0000_0000, 1'b0, 32'h0000_01FF, 1'b0}, // R2 all interior bits
    '{4'd2,  32'h0011_0000, 32'h0002_0000, 32'h0000_0000, 1'b0, 32'h0000_0061, 1'b0}, // R2 bit positions
    '{4'd4,  32'h08C0_0000, 32'h10B8_0000, 32'h18FF_0000, 1'b1, 32'h003F_6000, 1'b0}, // R3 R4 3D pack
    '{4'd11, 32'h08C0_0000, 32'h10B8_0000, 32'h18FF_0000, 1'b0, 32'h0007_3000, 1'b0}, // R11 z dropped
    '{4'd5,  32'h0000_0000, 32'h38F8_0000, 32'h38FF_0000, 1'b1, 32'h039F_E000, 1'b0}, // R5 10-bit mask, cap
    '{4'd5,  32'h0800_0000, 32'h38F8_0000, 32'h38FF_0000, 1'b1, 32'h073E_F000, 1'b0}, // R5 11-bit mask
    '{4'd6,  32'h50FF_0000, 32'h38F7_0000, 32'h0000_00C3, 1'b1, 32'h0000_280C, 1'b0}, // R6 pitch via x
    '{4'd1,  32'h3800_0000, 32'h4000_0000, 32'h0000_00FF, 1'b0, 32'h0000_7880, 1'b0}, // R1 pitch via y
    '{4'd7,  32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R7 x oob
    '{4'd7,  32'h0000_0000, 32'h8000_0000, 32'h0000_0000, 1'b0, 32'h0000_0000, 1'b1}, // R7 y oob
    '{4'd7,  32'h0000_0000, 32'h0000_0000, 32'h8000_0000, 1'b0, 32'h0000_0000, 1'b0}, // R7 z oob masked
    '{4'd7,  32'h0000_0000, 32'h0000_0000, 32'h8000_0000, 1'b1, 32'h0000_0000, 1'b1}, // R7 z oob in 3D
    '{4'd11, 32'h0000_0000, 32'h0000_0000, 32'h7FFF_FFFF, 1'b0, 32'h0000_0000, 1'b0}  // R11 z junk
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] x, input logic [31:0] y,
                       input logic [31:0] z, input logic d3, input logic v);
    in_x = x; in_y = y; in_z = z; in_3d = d3; in_valid = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 valid", {31'd0, out_valid}, 32'd0);
    check("R10 field", out_field, 32'd0);
    check("R10 oob", {31'd0, out_oob}, 32'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].x, VECS[i].y, VECS[i].z, VECS[i].d3, 1'b1);
      check("R9 valid", {31'd0, out_valid}, 32'd1);
      check($sformatf("R%0d field vec %0d", VECS[i].req, i), out_field, VECS[i].exp_field);
      check($sformatf("R%0d oob vec %0d", VECS[i].req, i), {31'd0, out_oob}, {31'd0, VECS[i].exp_oob});
    end

    // R9: idle cycle holds the last result while inputs change
    drive(32'h08C0_0000, 32'h10B8_0000, 32'h18FF_0000, 1'b1, 1'b1);
    drive(32'h8000_0000, 32'h4000_0000, 32'h0000_00FF, 1'b0, 1'b0);
    check("R9 idle valid", {31'd0, out_valid}, 32'd0);
    check("R9 idle field", out_field, 32'h003F_6000);
    check("R9 idle oob", {31'd0, out_oob}, 32'd0);

    // R9: back-to-back accepts
    drive(32'h8000_0000, 32'h0000_0000, 32'h0000_0000, 1'b0, 1'b1);
    check("R9 b2b oob", {31'd0, out_oob}, 32'd1);
    drive(32'h0011_0000, 32'h0002_0000, 32'h0000_0000, 1'b0, 1'b1);
    check("R9 b2b field", out_field, 32'h0000_0061);
    check("R9 b2b oob clear", {31'd0, out_oob}, 32'd0);

    // R10: reset mid-stream clears everything
    in_x = 32'h8000_0000;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10 mid valid", {31'd0, out_valid}, 32'd0);
    check("R10 mid field", out_field, 32'd0);
    check("R10 mid oob", {31'd0, out_oob}, 32'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule